// File: doc/BRIEF.md
# Escaped Frame Transmitter

This block turns a payload held in an external byte buffer into a byte-stuffed frame for a serial link. It hands the frame to a downstream UART transmitter one byte at a time over a valid/ready handshake. A frame opens with a two-byte start marker and closes with a two-byte end marker. Any payload byte that equals the escape code is sent twice, so the receiving side can tell data apart from the markers.

Instead of a frame, the block can send a standalone two-byte interrupt notification over the same output path. The link is half-duplex. While a frame or a notification is going out, the busy output is high, and the neighbouring receiver uses it to ignore incoming bytes. A one-cycle done pulse marks the end of every transmission, and the receiver then returns to its idle state.

The byte codes are parameters. Their default values are: escape 0xAA, start 0xFF, end 0x00 and interrupt 0xA5.

Top module: `esc_frame_tx`

## Requirements
- R1: After reset, busy, tx_valid and done are all 0.
- R2: A frame request sends 0xAA, then 0xFF, then the payload bytes from buffer addresses 0 to frame_len-1 in order, then 0xAA, then 0x00.
- R3: A payload byte equal to 0xAA is sent as two consecutive 0xAA bytes. rd_addr keeps the address of that byte during both of them and moves on only after the second one has been accepted.
- R4: A frame with frame_len = 0 sends exactly the four bytes 0xAA 0xFF 0xAA 0x00.
- R5: An interrupt request sends exactly the two bytes 0xAA then 0xA5, with no start or end marker around them.
- R6: done is high for exactly one cycle, in the cycle after the last byte of a frame or notification is accepted. In that same cycle busy is already 0.
- R7: busy and tx_valid are equal at all times. They go high in the cycle after a request is accepted and stay high until the last byte is accepted.
- R8: Requests are sampled only while busy is 0. A frame or interrupt request made while busy is 1 has no effect. If both requests arrive together while idle, the frame request is taken.
- R9: While tx_valid is 1 and tx_ready is 0, tx_data and rd_addr hold their values. The output advances only on a cycle where tx_valid and tx_ready are both 1.
- R10: rd_addr is 0 when a frame starts. It increases by one for each payload byte whose transmission completes, and it equals frame_len while the end marker is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_req | input | 1 | Start-frame request, sampled while idle |
| frame_len | input | LEN_W | Payload length in bytes, captured together with frame_req |
| intr_req | input | 1 | Start-interrupt-notification request, sampled while idle |
| rd_addr | output | LEN_W | Buffer read address |
| rd_data | input | 8 | Buffer read data for rd_addr, combinational |
| tx_data | output | 8 | Byte offered to the UART transmitter |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | UART transmitter accepts tx_data |
| busy | output | 1 | Transmission in progress; inhibits the receiver |
| done | output | 1 | One-cycle pulse after a transmission completes |

## Verification
A wrong machine state shows up directly in the accepted byte stream. A missed escape state drops the second 0xAA. A premature end state cuts the payload short. A state that lingers leaves busy high after the last byte, so done never arrives.

A read counter that steps too early shows in rd_addr on the very next handshake, which is why the bench records the address together with each accepted byte. Stall and hold faults are caught at the first cycle where tx_ready is low, because tx_data or rd_addr would then change under a pending byte.

// File: rtl/eft_pkg.sv
package eft_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SOF1,
      ST_SOF2,
      ST_DATA,
      ST_ESC,
      ST_EOF2,
      ST_INT1,
      ST_INT2
   } eft_state_e;

endpackage

// File: rtl/eft_rd_ctr.sv
module eft_rd_ctr #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [LEN_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   // R10: the address either clears or steps by exactly one
   assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/eft_fsm.sv
module eft_fsm
   import eft_pkg::*;
#(
   parameter int              LEN_W    = 8,
   parameter logic [BYTE_W-1:0] ESC_CODE = 8'hAA,
   parameter logic [BYTE_W-1:0] SOF_CODE = 8'hFF,
   parameter logic [BYTE_W-1:0] EOF_CODE = 8'h00,
   parameter logic [BYTE_W-1:0] INT_CODE = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_req,
   input  logic [LEN_W-1:0]  frame_len,
   input  logic              intr_req,
   input  logic [BYTE_W-1:0] rd_data,
   input  logic [LEN_W-1:0]  cnt,
   input  logic              tx_ready,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   output logic              busy,
   output logic              done,
   output logic              cnt_clr,
   output logic              cnt_inc
);

   eft_state_e        state_q, state_d;
   logic [LEN_W-1:0]  len_q;
   logic              hs;
   logic              at_end;
   logic              fin;

   assign hs       = tx_valid && tx_ready;
   assign at_end   = (cnt >= len_q);
   assign tx_valid = (state_q != ST_IDLE);
   assign busy     = tx_valid;

   always_comb begin
      state_d = state_q;
      tx_data = ESC_CODE;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      fin     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (frame_req) begin
               state_d = ST_SOF1;
               cnt_clr = 1'b1;
            end else if (intr_req) begin
               state_d = ST_INT1;
            end
         end
         ST_SOF1: if (hs) state_d = ST_SOF2;
         ST_SOF2: begin
            tx_data = SOF_CODE;
            if (hs) state_d = ST_DATA;
         end
         ST_DATA: begin
            if (at_end) begin
               if (hs) state_d = ST_EOF2;
            end else if (rd_data == ESC_CODE) begin
               if (hs) state_d = ST_ESC;
            end else begin
               tx_data = rd_data;
               cnt_inc = hs;
            end
         end
         ST_ESC: begin
            if (hs) begin
               cnt_inc = 1'b1;
               state_d = ST_DATA;
            end
         end
         ST_EOF2: begin
            tx_data = EOF_CODE;
            if (hs) begin
               state_d = ST_IDLE;
               fin     = 1'b1;
            end
         end
         ST_INT1: if (hs) state_d = ST_INT2;
         ST_INT2: begin
            tx_data = INT_CODE;
            if (hs) begin
               state_d = ST_IDLE;
               fin     = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         len_q   <= '0;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= fin;
         if (state_q == ST_IDLE && frame_req) len_q <= frame_len;
      end
   end

   // R9: a stalled byte keeps its state and read address
   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && state_q == $past(state_q) && $stable(cnt)));

   // R3: an escaped data byte is followed by its repeat, address unchanged
   assert_esc_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && hs && !at_end && rd_data == ESC_CODE)
      |=> (state_q == ST_ESC && tx_data == ESC_CODE && cnt == $past(cnt)));

   // R10: the read address never runs past the captured length
   assert_no_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA || state_q == ST_ESC || state_q == ST_EOF2) |-> (cnt <= len_q));

   // R6: busy falls exactly when done pulses
   assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && !busy));

   // R6: done is never high while busy
   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R2: an accepted frame request opens with the escape byte
   assert_frame_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && frame_req) |=> (busy && tx_data == ESC_CODE && cnt == '0));

   // R8: a busy machine does not restart on a new request
   assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state_q != ST_EOF2 && state_q != ST_INT2) |=> busy);

endmodule

// File: rtl/esc_frame_tx.sv
module esc_frame_tx
   import eft_pkg::*;
#(
   parameter int                LEN_W    = 8,
   parameter logic [BYTE_W-1:0] ESC_CODE = 8'hAA,
   parameter logic [BYTE_W-1:0] SOF_CODE = 8'hFF,
   parameter logic [BYTE_W-1:0] EOF_CODE = 8'h00,
   parameter logic [BYTE_W-1:0] INT_CODE = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_req,
   input  logic [LEN_W-1:0]  frame_len,
   input  logic              intr_req,
   output logic [LEN_W-1:0]  rd_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              busy,
   output logic              done
);

   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("esc_frame_tx: LEN_W must lie in 1..16");
      end
      if (ESC_CODE == SOF_CODE || ESC_CODE == EOF_CODE || ESC_CODE == INT_CODE) begin : g_bad_code
         $error("esc_frame_tx: marker codes must differ from the escape code");
      end
   endgenerate

   logic             cnt_clr;
   logic             cnt_inc;
   logic [LEN_W-1:0] cnt;

   eft_rd_ctr #(.LEN_W(LEN_W)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (cnt)
   );

   eft_fsm #(
      .LEN_W    (LEN_W),
      .ESC_CODE (ESC_CODE),
      .SOF_CODE (SOF_CODE),
      .EOF_CODE (EOF_CODE),
      .INT_CODE (INT_CODE)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_req (frame_req),
      .frame_len (frame_len),
      .intr_req  (intr_req),
      .rd_data   (rd_data),
      .cnt       (cnt),
      .tx_ready  (tx_ready),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .busy      (busy),
      .done      (done),
      .cnt_clr   (cnt_clr),
      .cnt_inc   (cnt_inc)
   );

   assign rd_addr = cnt;

   // R7: the valid and busy outputs agree
   assert_valid_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid == busy);

endmodule

// File: tb/esc_frame_tx_tb_top.sv
`timescale 1ns/1ps
module esc_frame_tx_tb_top;

   localparam int LEN_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             frame_req = 1'b0;
   logic [LEN_W-1:0] frame_len = '0;
   logic             intr_req = 1'b0;
   logic [LEN_W-1:0] rd_addr;
   logic [7:0]       rd_data;
   logic [7:0]       tx_data;
   logic             tx_valid;
   logic             tx_ready = 1'b1;
   logic             busy;
   logic             done;

   always #2.5 clk = ~clk;

   logic [7:0] buf_mem [0:255];
   assign rd_data = buf_mem[rd_addr];

   esc_frame_tx #(.LEN_W(LEN_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .frame_len(frame_len),
      .intr_req(intr_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .busy(busy), .done(done)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // capture of accepted bytes and their read addresses
   logic [7:0] cap_b [0:1023];
   int         cap_a [0:1023];
   int         cap_n = 0;
   int         done_cnt = 0;
   int         hold_err = 0;
   int         vb_err = 0;
   int         done_err = 0;
   logic       prev_stall = 1'b0;
   logic [7:0] prev_data = '0;
   logic [LEN_W-1:0] prev_addr = '0;
   logic       prev_done = 1'b0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (tx_valid !== busy) vb_err++;
         if (prev_stall && (tx_data !== prev_data || rd_addr !== prev_addr || !tx_valid)) hold_err++;
         if (done && (busy || prev_done)) done_err++;
         if (done) done_cnt++;
         if (tx_valid && tx_ready) begin
            cap_b[cap_n] = tx_data;
            cap_a[cap_n] = int'(rd_addr);
            cap_n++;
         end
         prev_stall = tx_valid && !tx_ready;
         prev_data  = tx_data;
         prev_addr  = rd_addr;
         prev_done  = done;
      end
   end

   // ready pattern: 0 always ready, 1 pseudo-random, 2 alternating
   int         ready_mode = 0;
   logic [7:0] lfsr = 8'h5B;
   always @(negedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (ready_mode)
         1:       tx_ready <= lfsr[0];
         2:       tx_ready <= ~tx_ready;
         default: tx_ready <= 1'b1;
      endcase
   end

   logic [7:0] exp_b [0:1023];
   int         exp_a [0:1023];
   int         exp_n;

   task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic push(input logic [7:0] b, input int a);
      exp_b[exp_n] = b;
      exp_a[exp_n] = a;
      exp_n++;
   endtask

   task automatic build_frame(input int len);
      exp_n = 0;
      push(8'hAA, 0);
      push(8'hFF, 0);
      for (int i = 0; i < len; i++) begin
         if (buf_mem[i] == 8'hAA) begin
            push(8'hAA, i);
            push(8'hAA, i);
         end else begin
            push(buf_mem[i], i);
         end
      end
      push(8'hAA, len);
      push(8'h00, len);
   endtask

   task automatic compare(input int base, input string req);
      int bad = -1;
      check(cap_n - base == exp_n, req, "byte count", cap_n - base, exp_n);
      for (int i = 0; i < exp_n && i < cap_n - base; i++) begin
         if (bad < 0 && (cap_b[base+i] !== exp_b[i] || (exp_a[i] >= 0 && cap_a[base+i] != exp_a[i])))
            bad = i;
      end
      if (bad >= 0)
         check(1'b0, req, $sformatf("byte/addr at index %0d", bad),
               int'(cap_b[base+bad]) * 1000 + cap_a[base+bad],
               int'(exp_b[bad]) * 1000 + exp_a[bad]);
      else
         check(1'b1, req, "content", 0, 0);
   endtask

   task automatic wait_done(input int d0);
      while (done_cnt == d0) @(negedge clk);
   endtask

   task automatic fill(input int len, input int kind);
      for (int i = 0; i < len; i++) begin
         case (kind)
            0:       buf_mem[i] = (i % 3 == 1) ? 8'hAA : 8'((i * 37 + 5) & 255);
            1:       buf_mem[i] = 8'hAA;
            default: buf_mem[i] = (8'((i * 11 + 1) & 255) == 8'hAA) ? 8'h55 : 8'((i * 11 + 1) & 255);
         endcase
      end
   endtask

   task automatic t_reset();
      check(busy == 1'b0 && tx_valid == 1'b0 && done == 1'b0, "R1", "reset outputs",
            {busy, tx_valid, done}, 0);
   endtask

   task automatic t_frame(input int len, input int kind, input int mode, input string req);
      int base, d0;
      fill(len, kind);
      build_frame(len);
      ready_mode = mode;
      base = cap_n;
      d0 = done_cnt;
      @(negedge clk);
      frame_req = 1'b1;
      frame_len = LEN_W'(len);
      @(negedge clk);
      frame_req = 1'b0;
      check(busy == 1'b1 && tx_valid == 1'b1, "R7", "busy after request", busy, 1);
      wait_done(d0);
      compare(base, req);
      check(busy == 1'b0, "R6", "busy low with done", busy, 0);
      ready_mode = 0;
   endtask

   task automatic t_intr();
      int base, d0;
      exp_n = 0;
      push(8'hAA, -1);
      push(8'hA5, -1);
      ready_mode = 1;
      base = cap_n;
      d0 = done_cnt;
      @(negedge clk);
      intr_req = 1'b1;
      @(negedge clk);
      intr_req = 1'b0;
      check(busy == 1'b1, "R7", "busy after interrupt request", busy, 1);
      wait_done(d0);
      compare(base, "R5");
      ready_mode = 0;
   endtask

   task automatic t_ignore_busy();
      int base, d0, n_after;
      fill(6, 0);
      build_frame(6);
      ready_mode = 2;
      base = cap_n;
      d0 = done_cnt;
      @(negedge clk);
      frame_req = 1'b1;
      frame_len = 8'd6;
      @(negedge clk);
      frame_req = 1'b0;
      repeat (3) @(negedge clk);
      intr_req = 1'b1;
      frame_req = 1'b1;
      frame_len = 8'd2;
      @(negedge clk);
      intr_req = 1'b0;
      frame_req = 1'b0;
      wait_done(d0);
      compare(base, "R8");
      n_after = cap_n;
      repeat (12) @(negedge clk);
      check(cap_n == n_after && busy == 1'b0, "R8", "no transmission after ignored request",
            cap_n - n_after, 0);
      ready_mode = 0;
   endtask

   task automatic t_both_req();
      int base, d0;
      fill(1, 2);
      build_frame(1);
      base = cap_n;
      d0 = done_cnt;
      @(negedge clk);
      frame_req = 1'b1;
      intr_req = 1'b1;
      frame_len = 8'd1;
      @(negedge clk);
      frame_req = 1'b0;
      intr_req = 1'b0;
      wait_done(d0);
      compare(base, "R8");
   endtask

   task automatic t_monitors();
      check(hold_err == 0, "R9", "stall hold violations", hold_err, 0);
      check(vb_err == 0, "R7", "valid/busy mismatches", vb_err, 0);
      check(done_err == 0, "R6", "done pulse violations", done_err, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) buf_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_frame(0, 0, 0, "R4");
      t_frame(5, 2, 0, "R2");
      t_frame(9, 0, 0, "R3");
      t_frame(4, 1, 1, "R3");
      t_frame(20, 0, 1, "R10");
      t_frame(12, 2, 2, "R9");
      t_intr();
      t_ignore_busy();
      t_both_req();
      t_frame(0, 0, 1, "R4");
      t_monitors();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule